// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Accumulator

This block keeps a running 16-bit cyclic redundancy check over a stream of 4-bit data nibbles. A producer (typically the read-data path of a nibble-wide memory) presents one nibble together with a valid strobe. Each strobed nibble is folded into the checksum within a single clock, so a new nibble can be accepted on every cycle.

The generator is x^16 + x^12 + x^5 + 1 used in reflected form, with the low bits of the state consumed first. The register update for one nibble `d` is `next = (crc >> 4) ^ T[(crc ^ d) & 0xF]`, where `T[i] = i * 0x1081`.

Software reaches the state through a small register port of four nibble-wide locations. Each location can be read, and a write to one location overwrites just that slice of the state. Firmware uses this to seed, save or restore a checksum one nibble at a time.

Top module: `nibcrc16_acc`

## Requirements
- R1: While `rst_n` is low the checksum is 0x0000, and it reads as 0x0000 after reset is released.
- R2: On a rising clock edge with `upd_valid` high and `reg_wr` low, the state becomes `(crc >> 4) ^ (((crc ^ upd_nib) & 0xF) * 0x1081)`, visible on `crc_out` after that edge.
- R3: Starting from 0x0000, folding in nibble value n gives n*0x1081. For example, 1 gives 0x1081 and 15 gives 0xF78F.
- R4: On an edge with neither `upd_valid` nor `reg_wr` high, the checksum is unchanged.
- R5: `reg_rdata` combinationally returns the selected slice: select 0 is bits 3:0, 1 is bits 7:4, 2 is bits 11:8 and 3 is bits 15:12.
- R6: A write (`reg_wr` high at an edge) loads `reg_wdata` into the slice named by `reg_sel` and leaves the other three slices unchanged.
- R7: When `reg_wr` and `upd_valid` are high on the same edge, the write is applied and the stream nibble is discarded.
- R8: Changing `reg_sel` and reading `reg_rdata` never changes the checksum.
- R9: Nibbles strobed on consecutive cycles are each folded in, one per edge, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Stream nibble valid strobe |
| upd_nib | input | 4 | Stream data nibble |
| reg_sel | input | 2 | Register port slice select |
| reg_wr | input | 1 | Register port write strobe |
| reg_wdata | input | 4 | Register port write data |
| reg_rdata | output | 4 | Register port read data (selected slice) |
| crc_out | output | 16 | Full checksum state |

## Verification
A register-port write and a stream update can land on the same clock edge. The bench provokes this by driving `reg_wr` and `upd_valid` together in one cycle, with stream nibbles that would change every slice. It then judges the result against a model that applies only the write. The write must appear in the selected slice, and the other three slices must hold their prior values rather than the values the stream nibble would have given.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;

   // Selects how one data nibble is folded into the state.
   typedef enum int {
      STEP_TABLE  = 0,   // shift by a nibble, xor a computed per-index constant
      STEP_SERIAL = 1    // unrolled bit-by-bit reflected shift
   } step_impl_e;

   localparam int unsigned DEF_CRC_W = 16;
   localparam int unsigned DEF_NIB_W = 4;
   // x^16 + x^12 + x^5 + 1, bit-reversed for right-shifting operation
   localparam logic [DEF_CRC_W-1:0] DEF_POLY_REFL = 16'h8408;

endpackage

// File: rtl/nibcrc_step.sv
module nibcrc_step
   import nibcrc_pkg::*;
#(
   parameter int unsigned          CRC_W     = DEF_CRC_W,
   parameter int unsigned          NIB_W     = DEF_NIB_W,
   parameter logic [CRC_W-1:0]     POLY_REFL = DEF_POLY_REFL,
   parameter step_impl_e           IMPL      = STEP_TABLE
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [NIB_W-1:0] nib_in,
   output logic [CRC_W-1:0] crc_nxt
);

   localparam int unsigned TBL_N = 1 << NIB_W;

   if (NIB_W < 1 || NIB_W > 8) begin : g_bad_nib_w
      $error("nibcrc_step: NIB_W must lie in 1..8");
   end
   if (NIB_W >= CRC_W) begin : g_bad_ratio
      $error("nibcrc_step: NIB_W must be narrower than CRC_W");
   end

   // Reflected shift of the state over NIB_W data bits, low bit first.
   function automatic logic [CRC_W-1:0] shift_bits(input logic [CRC_W-1:0] c,
                                                   input logic [NIB_W-1:0] d);
      logic [CRC_W-1:0] r;
      r = c;
      for (int b = 0; b < NIB_W; b++) begin
         if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

   if (IMPL == STEP_TABLE) begin : g_table
      logic [CRC_W-1:0] tbl [TBL_N];
      logic [NIB_W-1:0] idx;
      for (genvar i = 0; i < TBL_N; i++) begin : g_ent
         assign tbl[i] = shift_bits(CRC_W'(i), '0);
      end
      assign idx     = crc_in[NIB_W-1:0] ^ nib_in;
      assign crc_nxt = (crc_in >> NIB_W) ^ tbl[idx];
   end else begin : g_serial
      assign crc_nxt = shift_bits(crc_in, nib_in);
   end

endmodule

// File: rtl/nibcrc_regfile.sv
module nibcrc_regfile #(
   parameter int unsigned CRC_W    = 16,
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned NUM_REGS = CRC_W / NIB_W,
   parameter int unsigned SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic [CRC_W-1:0] crc_q,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic             reg_wr,
   input  logic [NIB_W-1:0] reg_wdata,
   output logic             wr_hit,
   output logic [CRC_W-1:0] wr_image,
   output logic [NIB_W-1:0] reg_rdata
);

   if (NUM_REGS * NIB_W != CRC_W) begin : g_bad_split
      $error("nibcrc_regfile: CRC_W must be a whole number of slices");
   end

   logic [NIB_W-1:0]    slice   [NUM_REGS];
   logic [NUM_REGS-1:0] sel_hot;

   // Slice g lives at bits g*NIB_W upward: select 0 is least significant.
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
      assign sel_hot[g]                   = (reg_sel == SEL_W'(g));
      assign slice[g]                     = crc_q[g*NIB_W +: NIB_W];
      assign wr_image[g*NIB_W +: NIB_W]   = (reg_wr && sel_hot[g]) ? reg_wdata
                                                                   : slice[g];
   end

   assign wr_hit    = reg_wr && (sel_hot != '0);
   assign reg_rdata = (sel_hot != '0) ? slice[reg_sel] : '0;

endmodule

// File: rtl/nibcrc_state.sv
module nibcrc_state #(
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [CRC_W-1:0] wr_image,
   input  logic             step_en,
   input  logic [CRC_W-1:0] step_image,
   output logic [CRC_W-1:0] crc_q
);

   // Register-port write outranks the stream update.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= '0;
      else if (wr_hit)  crc_q <= wr_image;
      else if (step_en) crc_q <= step_image;
   end

   p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> crc_q == '0)
      else $error("R1: state not clear during reset");

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !step_en) |=> $stable(crc_q))
      else $error("R4: state moved without a cause");

endmodule

// File: rtl/nibcrc16_acc.sv
module nibcrc16_acc
   import nibcrc_pkg::*;
#(
   parameter int unsigned      CRC_W     = DEF_CRC_W,
   parameter int unsigned      NIB_W     = DEF_NIB_W,
   parameter logic [CRC_W-1:0] POLY_REFL = DEF_POLY_REFL,
   parameter step_impl_e       IMPL      = STEP_TABLE,
   localparam int unsigned     NUM_REGS  = CRC_W / NIB_W,
   localparam int unsigned     SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_valid,
   input  logic [NIB_W-1:0] upd_nib,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic             reg_wr,
   input  logic [NIB_W-1:0] reg_wdata,
   output logic [NIB_W-1:0] reg_rdata,
   output logic [CRC_W-1:0] crc_out
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] step_out;
   logic [CRC_W-1:0] wr_image;
   logic             wr_hit;

   nibcrc_step #(
      .CRC_W(CRC_W), .NIB_W(NIB_W), .POLY_REFL(POLY_REFL), .IMPL(IMPL)
   ) u_step (
      .crc_in (crc_q),
      .nib_in (upd_nib),
      .crc_nxt(step_out)
   );

   nibcrc_regfile #(
      .CRC_W(CRC_W), .NIB_W(NIB_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
   ) u_regs (
      .crc_q    (crc_q),
      .reg_sel  (reg_sel),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .wr_hit   (wr_hit),
      .wr_image (wr_image),
      .reg_rdata(reg_rdata)
   );

   nibcrc_state #(.CRC_W(CRC_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .wr_image  (wr_image),
      .step_en   (upd_valid),
      .step_image(step_out),
      .crc_q     (crc_q)
   );

   assign crc_out = crc_q;

   // Checking aids: slice mask and positioned write data for the current select.
   logic [CRC_W-1:0] chk_mask;
   logic [CRC_W-1:0] chk_wdata;
   assign chk_mask  = {{(CRC_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} << (int'(reg_sel) * NIB_W);
   assign chk_wdata = CRC_W'(reg_wdata) << (int'(reg_sel) * NIB_W);

   p_wr_slice_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (crc_q & $past(chk_mask)) == $past(chk_wdata))
      else $error("R6: written slice wrong");

   p_wr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (crc_q & ~$past(chk_mask)) == ($past(crc_q) & ~$past(chk_mask)))
      else $error("R6: neighbouring slice disturbed");

   p_wr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && upd_valid) |=>
         crc_q == (($past(crc_q) & ~$past(chk_mask)) | $past(chk_wdata)))
      else $error("R7: stream nibble leaked past a write");

   p_stream_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !reg_wr) |=> crc_q == $past(step_out))
      else $error("R2: stream update not applied");

endmodule

// File: tb/nibcrc16_acc_bench.sv
module nibcrc16_acc_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       upd_valid = 1'b0;
   logic [3:0] upd_nib = '0;
   logic [1:0] reg_sel = '0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic [15:0] crc_out;

   int tests = 0;
   int fails = 0;
   logic [15:0] model = '0;
   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   nibcrc16_acc u_nibcrc16_acc (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_nib(upd_nib),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .crc_out(crc_out)
   );

   function automatic logic [15:0] fold(input logic [15:0] c, input logic [3:0] n);
      logic [15:0] k;
      k = 16'((c ^ 16'(n)) & 16'hF);
      return (c >> 4) ^ 16'(k * 16'h1081);
   endfunction

   task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Driver: one cycle of stimulus; the expected state after the edge is queued.
   task automatic cyc(input logic v, input logic [3:0] n, input logic w,
                      input logic [1:0] s, input logic [3:0] wd, input string tag);
      @(negedge clk);
      upd_valid = v; upd_nib = n; reg_wr = w; reg_sel = s; reg_wdata = wd;
      #1;
      check(16'(reg_rdata), 16'(model[int'(s)*4 +: 4]), "R5 read slice");
      if (w)      model[int'(s)*4 +: 4] = wd;
      else if (v) model = fold(model, n);
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input logic [1:0] s, input string tag);
      cyc(1'b0, 4'h0, 1'b0, s, 4'h0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      upd_valid = 1'b0; reg_wr = 1'b0;
      rst_n = 1'b0;
      model = '0;
      #1;
      check(crc_out, 16'h0000, "R1 clear in reset");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: compares the state after each driven edge against the queue.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(crc_out, e, t);
      end
   end

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [3:0] lf;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 check(crc_out, 16'h0000, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check(crc_out, 16'h0000, "R1 after release");

      // R3: single nibbles from zero against literal table values
      cyc(1'b1, 4'h1, 1'b0, 2'd0, 4'h0, "R3 nibble 1");
      idle(2'd0, "R4 idle");
      #1 check(crc_out, 16'h1081, "R3 literal 0x1081");
      do_reset();
      cyc(1'b1, 4'hF, 1'b0, 2'd0, 4'h0, "R3 nibble F");
      idle(2'd1, "R4 idle");
      #1 check(crc_out, 16'hF78F, "R3 literal 0xF78F");

      // R2/R9: back-to-back streams of several patterns
      for (int i = 0; i < 16; i++) cyc(1'b1, 4'(i), 1'b0, 2'd0, 4'h0, "R9 ascending");
      for (int i = 0; i < 8; i++)  cyc(1'b1, 4'hA, 1'b0, 2'd1, 4'h0, "R2 constant A");
      lf = 4'h9;
      for (int i = 0; i < 20; i++) begin
         cyc(1'b1, lf, 1'b0, 2'(i), 4'h0, "R9 lfsr stream");
         lf = {lf[2:0], lf[3] ^ lf[2]};
      end
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 4'h5, 1'b0, 2'd2, 4'h0, "R2 gapped");
         idle(2'd3, "R4 gap");
      end

      // R8: walk the select with no write and no strobe
      for (int i = 0; i < 8; i++) idle(2'(i), "R8 read leaves state");

      // R6: write each slice, then read all back
      cyc(1'b0, 4'h0, 1'b1, 2'd0, 4'h3, "R6 write slice 0");
      cyc(1'b0, 4'h0, 1'b1, 2'd2, 4'hC, "R6 write slice 2");
      cyc(1'b0, 4'h0, 1'b1, 2'd3, 4'h7, "R6 write slice 3");
      cyc(1'b0, 4'h0, 1'b1, 2'd1, 4'hE, "R6 write slice 1");
      for (int i = 0; i < 4; i++) idle(2'(i), "R5 readback");
      #1 check(crc_out, 16'h7CE3, "R6 seeded value");

      // R7: write and stream in the same cycle, stream nibble dropped
      cyc(1'b1, 4'hB, 1'b1, 2'd1, 4'h0, "R7 write wins");
      cyc(1'b1, 4'h6, 1'b1, 2'd3, 4'h9, "R7 write wins top");
      idle(2'd0, "R4 after collision");
      #1 check(crc_out, 16'h9C03, "R7 collision value");
      cyc(1'b1, 4'h2, 1'b0, 2'd0, 4'h0, "R2 after seed");

      // R1: reset in the middle of activity
      cyc(1'b1, 4'h4, 1'b0, 2'd0, 4'h0, "R2 pre reset");
      do_reset();
      idle(2'd2, "R1 after mid reset");
      cyc(1'b1, 4'h7, 1'b0, 2'd0, 4'h0, "R2 post reset");
      idle(2'd0, "R4 drain");
      repeat (3) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule